// File: doc/BRIEF.md
# Matrix Keypad Scanner with Tick-Based Debounce

This block scans a 4x4 matrix keypad and reports a debounced key code. It drives a one-hot row select that moves to the next row at a fixed interval while no column is active. When the column lines show activity for the row being driven, the scan stops and holds that row. The held row and the active column together give a key code from 0 to 15.

Press confirmation runs from a slow debounce tick, typically 64 Hz, so that the contacts are sampled only after they have settled. A press counts only when the same single column reads active on two ticks in a row. The block then raises a one-cycle valid strobe. A release also needs two quiet ticks in a row before scanning starts again. Column inputs pass through a synchroniser before any logic uses them.

Top module: `keypad_scanner`

## Requirements
- R1: After reset the row select is 0001 (row 0 driven), the key code is 0 and key-valid is low.
- R2: While no column is active, the row select stays one-hot and moves to the next row every STEP_CYCLES system clocks, in the order 0001, 0010, 0100, 1000, 0001. Bit r drives row r.
- R3: When a column line reads active at the end of a row interval, the row select stops and holds that row. A press in row 0 holds the output at 0001.
- R4: The confirmed key code is row_index*4 + column_index. Column bit c is column c, and a column reads active when high.
- R5: A press is confirmed only after two consecutive ticks on which the same single column reads active. A single such tick raises no strobe.
- R6: key-valid is high for exactly one system clock for each confirmed press. It does not repeat while the key stays held.
- R7: A reading with more than one active column is never confirmed, however many ticks it lasts.
- R8: After a confirmed press, the row stays held until two consecutive ticks read no active column. Scanning then resumes.
- R9: If the column reading drops to inactive on a tick before confirmation, the attempt is dropped without a strobe and scanning resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| db_tick | input | 1 | One-cycle debounce tick (slow, e.g. 64 Hz) |
| col_in | input | 4 | Column sense lines, high = contact closed in the driven row |
| row_drive | output | 4 | One-hot row select |
| key_code | output | 4 | Code of the last confirmed key |
| key_valid | output | 1 | One-cycle strobe on each confirmed press |

## Verification
The bench goes after the edges of the confirmation window. A design that counted the capture itself as a tick would strobe after one tick. A design that left out the release count would start scanning again while the key is still down and then report the same press twice. A held key that fails to hold the row shows up as a row select that does not match the pressed row. An encoder that swaps row and column gives wrong codes for the asymmetric keys 3, 6, 9 and 12. Two columns down together, and a press that bounces open between ticks, must both end with no strobe.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

   typedef enum logic [1:0] {
      KS_SCAN = 2'd0,
      KS_ARM  = 2'd1,
      KS_HELD = 2'd2
   } kpd_state_e;

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("kpd_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("kpd_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/kpd_row_scan.sv
module kpd_row_scan #(
   parameter int ROWS        = 4,
   parameter int STEP_CYCLES = 4,
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            hit,
   output logic [ROWS-1:0] row_q,
   output logic            sample,
   output logic [RW-1:0]   row_idx
);

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("kpd_row_scan: ROWS must be at least 2");
      end
      if (STEP_CYCLES < 2) begin : g_bad_step
         $error("kpd_row_scan: STEP_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] step_cnt;

   assign sample = run && (step_cnt == CW'(STEP_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_cnt <= '0;
      end else if (!run || sample) begin
         step_cnt <= '0;
      end else begin
         step_cnt <= step_cnt + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= ROWS'(1);
      end else if (sample && !hit) begin
         row_q <= {row_q[ROWS-2:0], row_q[ROWS-1]};
      end
   end

   always_comb begin
      row_idx = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (row_q[r]) row_idx = RW'(r);
      end
   end

   assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(row_q));

   assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(row_q));

endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce
   import kpd_pkg::*;
#(
   parameter int ROWS    = 4,
   parameter int COLS    = 4,
   parameter int CONFIRM = 2,
   localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CLW    = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int CODE_W = $clog2(ROWS * COLS),
   localparam int TW     = $clog2(CONFIRM + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [COLS-1:0]   col_s,
   input  logic              sample,
   input  logic [RW-1:0]     row_idx,
   output logic              run,
   output logic              hit,
   output logic              key_valid,
   output logic [CODE_W-1:0] key_code
);

   generate
      if (CONFIRM < 1) begin : g_bad_confirm
         $error("kpd_debounce: CONFIRM must be at least 1");
      end
      if (COLS < 2) begin : g_bad_cols
         $error("kpd_debounce: COLS must be at least 2");
      end
   endgenerate

   kpd_state_e        state;
   logic [COLS-1:0]   cand;
   logic [TW-1:0]     cnt;
   logic [CLW-1:0]    col_idx;
   logic              single;
   logic              last_tick;
   logic [CODE_W-1:0] code_next;

   assign run       = (state == KS_SCAN);
   assign hit       = (col_s != '0);
   assign single    = $onehot(col_s);
   assign last_tick = (cnt == TW'(CONFIRM - 1));

   always_comb begin
      col_idx = '0;
      for (int c = 0; c < COLS; c++) begin
         if (col_s[c]) col_idx = CLW'(c);
      end
   end

   assign code_next = CODE_W'(row_idx) * CODE_W'(COLS) + CODE_W'(col_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= KS_SCAN;
         cand      <= '0;
         cnt       <= '0;
         key_valid <= 1'b0;
         key_code  <= '0;
      end else begin
         key_valid <= 1'b0;
         unique case (state)
            KS_SCAN: begin
               if (sample && hit) begin
                  cand  <= col_s;
                  cnt   <= '0;
                  state <= KS_ARM;
               end
            end
            KS_ARM: begin
               if (tick) begin
                  if (!hit) begin
                     cnt   <= '0;
                     state <= KS_SCAN;
                  end else if (col_s == cand && single) begin
                     if (last_tick) begin
                        cnt       <= '0;
                        key_valid <= 1'b1;
                        key_code  <= code_next;
                        state     <= KS_HELD;
                     end else begin
                        cnt <= cnt + TW'(1);
                     end
                  end else begin
                     cand <= col_s;
                     cnt  <= '0;
                  end
               end
            end
            KS_HELD: begin
               if (tick) begin
                  if (!hit) begin
                     if (last_tick) begin
                        cnt   <= '0;
                        state <= KS_SCAN;
                     end else begin
                        cnt <= cnt + TW'(1);
                     end
                  end else begin
                     cnt <= '0;
                  end
               end
            end
            default: state <= KS_SCAN;
         endcase
      end
   end

   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> !key_valid);

   assert_strobe_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> $past(tick));

   assert_strobe_single_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> $onehot($past(col_s)));

   assert_no_resume_while_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(col_s) == '0);

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int STEP_CYCLES = 4,
   parameter int CONFIRM     = 2,
   localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CODE_W = $clog2(ROWS * COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              db_tick,
   input  logic [COLS-1:0]   col_in,
   output logic [ROWS-1:0]   row_drive,
   output logic [CODE_W-1:0] key_code,
   output logic              key_valid
);

   generate
      if (STEP_CYCLES <= SYNC_STAGES) begin : g_bad_timing
         $error("keypad_scanner: STEP_CYCLES must exceed SYNC_STAGES");
      end
   endgenerate

   logic [COLS-1:0] col_s;
   logic            run;
   logic            hit;
   logic            sample;
   logic [RW-1:0]   row_idx;

   kpd_sync #(
      .WIDTH  (COLS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (col_in),
      .q     (col_s)
   );

   kpd_row_scan #(
      .ROWS        (ROWS),
      .STEP_CYCLES (STEP_CYCLES)
   ) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .hit     (hit),
      .row_q   (row_drive),
      .sample  (sample),
      .row_idx (row_idx)
   );

   kpd_debounce #(
      .ROWS    (ROWS),
      .COLS    (COLS),
      .CONFIRM (CONFIRM)
   ) u_deb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (db_tick),
      .col_s     (col_s),
      .sample    (sample),
      .row_idx   (row_idx),
      .run       (run),
      .hit       (hit),
      .key_valid (key_valid),
      .key_code  (key_code)
   );

endmodule

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;

   localparam int STEP = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       db_tick = 1'b0;
   logic [3:0] col_in;
   logic [3:0] row_drive;
   logic [3:0] key_code;
   logic       key_valid;
   logic [15:0] keys = '0;

   int checks = 0;
   int bad = 0;
   int pulses = 0;
   logic [3:0] last_code = '0;
   bit done = 0;

   always #2 clk = ~clk;

   keypad_scanner u_keypad_scanner (
      .clk       (clk),
      .rst_n     (rst_n),
      .db_tick   (db_tick),
      .col_in    (col_in),
      .row_drive (row_drive),
      .key_code  (key_code),
      .key_valid (key_valid)
   );

   // keypad model: column c is high when a closed key sits in a driven row
   always_comb begin
      col_in = '0;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            if (keys[r*4+c] && row_drive[r]) col_in[c] = 1'b1;
   end

   always @(negedge clk) begin
      if (key_valid) begin
         pulses <= pulses + 1;
         last_code <= key_code;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk) db_tick = 1'b1;
      @(negedge clk) db_tick = 1'b0;
      cyc(2);
   endtask

   // {row[7:6], col[5:4], expected code[3:0]}
   localparam logic [7:0] VEC [6] = '{
      {2'd0, 2'd0, 4'd0},
      {2'd0, 2'd3, 4'd3},
      {2'd1, 2'd2, 4'd6},
      {2'd2, 2'd1, 4'd9},
      {2'd3, 2'd0, 4'd12},
      {2'd3, 2'd3, 4'd15}
   };

   initial begin
      #800000;
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] seq [5];
      int nseq;
      int dwell;
      int p0;
      logic [3:0] prev;

      cyc(3);
      // R1 reset state
      chk(row_drive == 4'b0001, "R1 row", row_drive, 1);
      chk(key_code == 4'd0, "R1 code", key_code, 0);
      chk(key_valid == 1'b0, "R1 valid", key_valid, 0);
      @(negedge clk) rst_n = 1'b1;

      // R2 rotation order and dwell
      seq[0] = row_drive;
      nseq = 1;
      prev = row_drive;
      dwell = 0;
      for (int i = 0; i < 40 && nseq < 5; i++) begin
         cyc(1);
         dwell++;
         if (row_drive != prev) begin
            if (nseq >= 2) chk(dwell == STEP, "R2 dwell", dwell, STEP);
            seq[nseq] = row_drive;
            nseq++;
            prev = row_drive;
            dwell = 0;
         end
      end
      chk(nseq == 5, "R2 steps", nseq, 5);
      chk(seq[1] == 4'b0010, "R2 order1", seq[1], 2);
      chk(seq[2] == 4'b0100, "R2 order2", seq[2], 4);
      chk(seq[3] == 4'b1000, "R2 order3", seq[3], 8);
      chk(seq[4] == 4'b0001, "R2 wrap", seq[4], 1);

      // vector table: R3 R4 R5 R6 R8
      for (int v = 0; v < 6; v++) begin
         int r;
         int c;
         logic [3:0] hold;
         r = int'(VEC[v][7:6]);
         c = int'(VEC[v][5:4]);
         keys = '0;
         keys[r*4+c] = 1'b1;
         cyc(40);
         chk(row_drive == 4'(1 << r), "R3 frozen row", row_drive, 1 << r);
         p0 = pulses;
         tick();
         chk(pulses == p0, "R5 one tick", pulses - p0, 0);
         tick();
         chk(pulses == p0 + 1, "R5 confirm", pulses - p0, 1);
         chk(last_code == VEC[v][3:0], "R4 code", last_code, VEC[v][3:0]);
         tick();
         tick();
         tick();
         chk(pulses == p0 + 1, "R6 no repeat", pulses - p0, 1);
         keys = '0;
         cyc(10);
         tick();
         cyc(20);
         chk(row_drive == 4'(1 << r), "R8 hold after one quiet tick", row_drive, 1 << r);
         tick();
         hold = row_drive;
         cyc(6);
         chk(row_drive != hold, "R8 resume", row_drive, 0);
         chk(pulses == p0 + 1, "R6 single", pulses - p0, 1);
      end

      // R9 bounce: one matching tick, then open contact on the next tick
      keys = '0;
      keys[1*4+2] = 1'b1;
      cyc(40);
      p0 = pulses;
      tick();
      keys = '0;
      cyc(10);
      tick();
      cyc(10);
      tick();
      tick();
      chk(pulses == p0, "R9 bounce dropped", pulses - p0, 0);
      prev = row_drive;
      cyc(6);
      chk(row_drive != prev, "R9 scan resumed", row_drive, 0);

      // R7 two columns in one row
      keys = '0;
      keys[2*4+0] = 1'b1;
      keys[2*4+3] = 1'b1;
      cyc(40);
      chk(row_drive == 4'b0100, "R7 frozen on row 2", row_drive, 4);
      p0 = pulses;
      tick();
      tick();
      tick();
      tick();
      chk(pulses == p0, "R7 multi ignored", pulses - p0, 0);
      chk(key_code == 4'd15, "R7 code kept", key_code, 15);
      keys = '0;
      cyc(10);
      tick();

      // single key after multi still works
      keys[0*4+1] = 1'b1;
      cyc(40);
      p0 = pulses;
      tick();
      tick();
      chk(pulses == p0 + 1 && last_code == 4'd1, "R4 after multi", last_code, 1);
      keys = '0;

      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule